// File: doc/BRIEF.md
# Open-LED Test Mode Sequencer

This controller sits beside the serial shift register and output latches of a multi-channel constant-current LED sink driver. It watches the active-low output enable and the latch strobe on every rising clock edge. A short handshake on those two pins moves the driver from normal display mode into open-LED test mode, and a second handshake returns it. No dedicated mode pin is needed. While the entry handshake is in progress, the controller holds off latch updates so that the LE pulse belonging to the handshake does not overwrite the displayed pattern.

In test mode the controller runs capture windows. While output enable is low it samples a per-channel result built from the latched enable bit, the channel's sense-ok flag and the thermal flag. When output enable returns high after a long enough window, it pulses a load strobe and presents the error vector, which the data path then parallel-loads into the shift register. A window that is too short produces nothing. Captures may be repeated any number of times. The latches may be reloaded between captures, so that chosen patterns can be tested.

Top module: `open_led_seq`

## Requirements
- R1: While reset is asserted and after it is released, the block is in normal mode (`testMode`=0), with `latchInhibit`=0, `errLoad`=0 and `errVec` all zeros.
- R2: In normal mode, five consecutive rising-edge samples of {`oeN`,`le`} equal to 10, 00, 10, 11, 10 switch the block to test mode. `testMode` reads 1 right after the fifth edge.
- R3: A sample sequence that departs from the entry handshake in any step leaves the block in normal mode. Steady levels on `oeN` and `le` never change the mode.
- R4: In normal mode, `latchInhibit` is 1 exactly when the three most recent samples taken since the last mode change are 10, 00, 10 in that order (the first three entry steps). It is never 1 in test mode.
- R5: In test mode, five consecutive samples of {`oeN`,`le`} equal to 10, 00, 10, 10, 10 return the block to normal mode. The handshake ends with three clocks of `oeN` high, and sequence progress restarts from zero at every mode change.
- R6: In test mode, an edge that samples `oeN`=1 after at least three consecutive edges sampling `oeN`=0 raises `errLoad` for exactly one cycle.
- R7: The error vector loaded by R6 has bit i = `latchBits`[i] AND `senseOk`[i] AND NOT `thermFault`, taken at the last edge of the window with `oeN` low. Disabled channels, failed channels and any channel during a thermal fault all give 0.
- R8: A window of one or two low samples gives no `errLoad`, and `errVec` keeps its previous value. `errVec` changes only in a cycle where `errLoad` is 1.
- R9: Captures can be repeated in test mode. Each qualified window loads a fresh vector that reflects the latch, sense and thermal inputs of that window.
- R10: `errLoad` is never raised in normal mode, whatever `oeN` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all steps are taken on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| oeN | input | 1 | Output enable, active low |
| le | input | 1 | Latch strobe, active high |
| latchBits | input | 16 | Current output latch contents (1 = channel enabled) |
| senseOk | input | 16 | Per-channel sense result (1 = voltage above threshold) |
| thermFault | input | 1 | Over-temperature flag |
| testMode | output | 1 | 1 while in open-LED test mode |
| latchInhibit | output | 1 | Blocks the latch update during the entry handshake |
| errLoad | output | 1 | One-cycle strobe to parallel-load the error vector |
| errVec | output | 16 | Captured error code, 1 = channel enabled and passing |

## Verification
Each mode change, the load strobe and the error vector are registered, so they are due one clock edge after the sample that completes a handshake or ends a qualified window. `latchInhibit` depends only on state, so it also changes after the third matching edge. The bench drives inputs on falling edges. A behavioural model advances on the same rising edge, and all four outputs are compared with the model on the following falling edge. Directed checks read the outputs one time unit after the rising edge that should have caused the change, against values worked out by hand.

// File: rtl/open_led_seq_pkg.sv
package open_led_seq_pkg;

  // number of clock steps in either mode handshake
  localparam int SEQ_LEN = 5;
  // step index at which the entry handshake raises LE
  localparam int LE_STEP = 3;

  typedef struct packed {
    logic testMode;   // current mode
    logic sampleWin;  // evaluate channels this edge
    logic loadNow;    // qualified window closes this edge
  } ctrlStrobe_t;

  // {oeN, le} expected at step k of the handshake; exitSel picks the exit form
  function automatic logic [1:0] stepCode(input logic exitSel, input int k);
    logic [1:0] code;
    case (k)
      1:       code = 2'b00;
      3:       code = exitSel ? 2'b10 : 2'b11;
      default: code = 2'b10;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/open_led_seq_ctrl.sv
module open_led_seq_ctrl
  import open_led_seq_pkg::*;
#(
  parameter int MIN_WIN = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        oeN,
  input  logic        le,
  output ctrlStrobe_t strobe,
  output logic        latchInhibit
);

  localparam int VW = $clog2(SEQ_LEN + 1);
  localparam int WW = $clog2(MIN_WIN + 1);

  logic [SEQ_LEN-2:0][1:0] hist;      // hist[0] is the newest previous sample
  logic [VW-1:0]           validCnt;  // samples taken since the last mode change
  logic [WW-1:0]           lowCnt;    // consecutive low-enable samples in test mode
  logic                    modeQ;
  logic [1:0]              cur;
  logic                    seqHit;

  assign cur = {oeN, le};

  always_comb begin
    seqHit = (validCnt >= VW'(SEQ_LEN - 1));
    for (int k = 0; k < SEQ_LEN - 1; k++) begin
      if (hist[SEQ_LEN-2-k] != stepCode(modeQ, k)) seqHit = 1'b0;
    end
    if (cur != stepCode(modeQ, SEQ_LEN - 1)) seqHit = 1'b0;
  end

  always_comb begin
    latchInhibit = !modeQ && (validCnt >= VW'(LE_STEP));
    for (int k = 0; k < LE_STEP; k++) begin
      if (hist[LE_STEP-1-k] != stepCode(1'b0, k)) latchInhibit = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist     <= '0;
      validCnt <= '0;
      modeQ    <= 1'b0;
    end else begin
      hist <= {hist[SEQ_LEN-3:0], cur};
      if (seqHit) begin
        modeQ    <= ~modeQ;
        validCnt <= '0;
      end else if (validCnt < VW'(SEQ_LEN - 1)) begin
        validCnt <= validCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (!modeQ || oeN) begin
      lowCnt <= '0;
    end else if (lowCnt < WW'(MIN_WIN)) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  assign strobe.testMode  = modeQ;
  assign strobe.sampleWin = modeQ && !oeN;
  assign strobe.loadNow   = modeQ && oeN && (lowCnt >= WW'(MIN_WIN));

  // R2
  enter_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeQ) |-> ($past(oeN) == 1'b1) && ($past(le) == 1'b0));

  // R4
  inhibit_normal_chk: assert property (@(posedge clk) disable iff (!rstN)
    latchInhibit |-> !modeQ);

  // R8
  short_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadNow |-> $past(oeN) == 1'b0);

endmodule

// File: rtl/open_led_seq_dp.sv
module open_led_seq_dp
  import open_led_seq_pkg::*;
#(
  parameter int N_CH = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     strobe,
  input  logic [N_CH-1:0] latchBits,
  input  logic [N_CH-1:0] senseOk,
  input  logic            thermFault,
  output logic            errLoad,
  output logic [N_CH-1:0] errVec
);

  logic [N_CH-1:0] passBit;
  logic [N_CH-1:0] capVec;

  for (genvar i = 0; i < N_CH; i++) begin : g_chan
    assign passBit[i] = latchBits[i] & senseOk[i] & ~thermFault;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capVec  <= '0;
      errVec  <= '0;
      errLoad <= 1'b0;
    end else begin
      errLoad <= strobe.loadNow;
      if (strobe.sampleWin) capVec <= passBit;
      if (strobe.loadNow)   errVec <= capVec;
    end
  end

  // R6
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    errLoad |=> !errLoad);

  // R8
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !errLoad |-> $stable(errVec));

  // R10
  load_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    errLoad |-> strobe.testMode);

endmodule

// File: rtl/open_led_seq.sv
module open_led_seq
  import open_led_seq_pkg::*;
#(
  parameter int N_CH    = 16,
  parameter int MIN_WIN = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            oeN,
  input  logic            le,
  input  logic [N_CH-1:0] latchBits,
  input  logic [N_CH-1:0] senseOk,
  input  logic            thermFault,
  output logic            testMode,
  output logic            latchInhibit,
  output logic            errLoad,
  output logic [N_CH-1:0] errVec
);

  ctrlStrobe_t strobe;

  open_led_seq_ctrl #(.MIN_WIN(MIN_WIN)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .oeN          (oeN),
    .le           (le),
    .strobe       (strobe),
    .latchInhibit (latchInhibit)
  );

  open_led_seq_dp #(.N_CH(N_CH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .latchBits  (latchBits),
    .senseOk    (senseOk),
    .thermFault (thermFault),
    .errLoad    (errLoad),
    .errVec     (errVec)
  );

  assign testMode = strobe.testMode;

endmodule

// File: tb/open_led_seq_bench.sv
module open_led_seq_bench;

  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        oeN = 1'b0;
  logic        le = 1'b0;
  logic [15:0] latchBits = '0;
  logic [15:0] senseOk = '0;
  logic        thermFault = 1'b0;
  logic        testMode, latchInhibit, errLoad;
  logic [15:0] errVec;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #(PER/2) clk = ~clk;

  open_led_seq u_open_led_seq (
    .clk(clk), .rstN(rstN), .oeN(oeN), .le(le),
    .latchBits(latchBits), .senseOk(senseOk), .thermFault(thermFault),
    .testMode(testMode), .latchInhibit(latchInhibit),
    .errLoad(errLoad), .errVec(errVec)
  );

  // ---------------- behavioural reference ----------------
  logic [1:0] entPat [5] = '{2'b10, 2'b00, 2'b10, 2'b11, 2'b10};
  logic [1:0] extPat [5] = '{2'b10, 2'b00, 2'b10, 2'b10, 2'b10};
  logic [1:0] q[$];
  bit          mMode, mInh, mLoad;
  int          mLow;
  logic [15:0] mCap, mVec;

  function automatic bit tailMatches(int n, bit useExit);
    if (q.size() < n) return 1'b0;
    for (int k = 0; k < n; k++) begin
      logic [1:0] want = useExit ? extPat[k] : entPat[k];
      if (q[q.size() - n + k] != want) return 1'b0;
    end
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q.delete();
      mMode = 0; mInh = 0; mLoad = 0; mLow = 0; mCap = '0; mVec = '0;
    end else begin
      mLoad = 0;
      if (mMode) begin
        if (!oeN) begin
          mLow++;
          mCap = latchBits & senseOk & {16{~thermFault}};
        end else begin
          if (mLow >= 3) begin mLoad = 1; mVec = mCap; end
          mLow = 0;
        end
      end else begin
        mLow = 0;
      end
      q.push_back({oeN, le});
      if (q.size() > 5) void'(q.pop_front());
      if (q.size() == 5 && tailMatches(5, mMode)) begin
        mMode = !mMode;
        q.delete();
      end
      mInh = !mMode && tailMatches(3, 1'b0);
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(testMode == mMode, "R2 R5 testMode vs model", testMode, mMode);
      chk(latchInhibit == mInh, "R4 latchInhibit vs model", latchInhibit, mInh);
      chk(errLoad == mLoad, "R6 R10 errLoad vs model", errLoad, mLoad);
      chk(errVec == mVec, "R7 R8 errVec vs model", errVec, mVec);
    end
  end

  task automatic tick(logic o, logic l);
    @(negedge clk);
    oeN = o; le = l;
    @(posedge clk);
    #1;
  endtask

  task automatic seq(logic [1:0] p [5]);
    for (int k = 0; k < 5; k++) tick(p[k][1], p[k][0]);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
  endtask

  initial begin
    #(PER * 200000);
    if (!done) begin
      done = 1'b1;
      failCnt++; checkCnt++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    chk(testMode == 0 && latchInhibit == 0 && errLoad == 0 && errVec == 0,
        "R1 reset state", {testMode, latchInhibit, errLoad}, 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    chk(testMode == 0 && errVec == 0, "R1 after release", testMode, 0);

    // R10: enable toggling in normal mode gives no strobe
    repeat (4) tick(1'b0, 1'b0);
    tick(1'b1, 1'b0);
    chk(errLoad == 0, "R10 no strobe in normal mode", errLoad, 0);
    tick(1'b1, 1'b1);
    tick(1'b0, 1'b0);
    // R3 steady levels
    repeat (6) tick(1'b0, 1'b0);
    chk(testMode == 0, "R3 steady inputs keep normal", testMode, 0);

    // R3 broken handshake (step four wrong)
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b1, 1'b0);
    chk(latchInhibit == 1, "R4 inhibit after three steps", latchInhibit, 1);
    tick(1'b0, 1'b0);
    chk(latchInhibit == 0, "R4 inhibit drops on mismatch", latchInhibit, 0);
    tick(1'b1, 1'b0);
    chk(testMode == 0, "R3 broken handshake ignored", testMode, 0);
    tick(1'b0, 1'b0); tick(1'b0, 1'b0);

    // R2 proper entry
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b1, 1'b0);
    chk(latchInhibit == 1, "R4 inhibit before LE step", latchInhibit, 1);
    tick(1'b1, 1'b1);
    chk(testMode == 0, "R2 not yet in test mode", testMode, 0);
    tick(1'b1, 1'b0);
    chk(testMode == 1, "R2 entered test mode", testMode, 1);
    chk(latchInhibit == 0, "R4 no inhibit in test mode", latchInhibit, 0);

    // R6 R7 qualified capture
    latchBits = 16'hA5A5; senseOk = 16'hFF0F;
    repeat (3) tick(1'b0, 1'b0);
    chk(errLoad == 0, "R6 no strobe while enable low", errLoad, 0);
    tick(1'b1, 1'b0);
    chk(errLoad == 1, "R6 strobe on enable high", errLoad, 1);
    chk(errVec == 16'hA505, "R7 error code", errVec, 16'hA505);
    tick(1'b1, 1'b0);
    chk(errLoad == 0, "R6 strobe lasts one cycle", errLoad, 0);

    // R8 short window
    latchBits = 16'hFFFF; senseOk = 16'hFFFF;
    tick(1'b0, 1'b0); tick(1'b0, 1'b0); tick(1'b1, 1'b0);
    chk(errLoad == 0, "R8 short window no strobe", errLoad, 0);
    chk(errVec == 16'hA505, "R8 vector kept", errVec, 16'hA505);

    // R7 R9 thermal fault in repeated capture
    tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    thermFault = 1'b1;
    tick(1'b0, 1'b0);
    thermFault = 1'b0;
    tick(1'b1, 1'b0);
    chk(errLoad == 1 && errVec == 16'h0000, "R9 repeat capture with thermal fault",
        errVec, 16'h0000);

    // R9 new pattern
    latchBits = 16'hFFFF; senseOk = 16'h7FFE;
    repeat (4) tick(1'b0, 1'b0);
    tick(1'b1, 1'b0);
    chk(errVec == 16'h7FFE, "R9 fresh capture", errVec, 16'h7FFE);

    // R5 exit
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b1, 1'b0); tick(1'b1, 1'b0);
    chk(testMode == 1, "R5 still in test mode", testMode, 1);
    tick(1'b1, 1'b0);
    chk(testMode == 0, "R5 back to normal", testMode, 0);
    chk(errLoad == 0, "R8 exit window no strobe", errLoad, 0);

    repeat (4) tick(1'b0, 1'b0);
    tick(1'b1, 1'b0);
    chk(errLoad == 0, "R10 no strobe after exit", errLoad, 0);

    // re-enter and leave again
    seq(entPat);
    chk(testMode == 1, "R2 re-entry", testMode, 1);
    seq(extPat);
    chk(testMode == 0, "R5 second exit", testMode, 0);
    repeat (3) tick(1'b0, 1'b0);

    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule